// File: doc/BRIEF.md
# Low-Frequency Transponder Pulse-Width Write Modulator

This block switches the field enable of a 134 kHz reader front end so that a complete programming frame reaches a read/write transponder. A one-cycle start strobe captures a 64-bit data word, a 16-bit check value and an auto-check flag. The block then keeps the field on to charge the tag and sends the frame one bit per fixed-length slot. Each slot opens with a field-off gap whose length carries the bit value, and the field is on for the rest of the slot. After the last slot the field stays on for the programming period, then drops, and a one-cycle done pulse follows.

The frame is 14 bytes, each sent least significant bit first, in this order: a keyword byte 0xBB, a password byte 0xEB, the eight data bytes from the lowest to the highest, the low and then the high byte of the check value, and the trailer bytes 0x00 and then 0x03. The check value is computed on chip when the auto flag is set or when the supplied value is zero. All timing is counted in microsecond ticks, which a divider derives from the system clock. The charge, programming, slot and gap lengths are parameters given in microseconds.

Top module: `lfw_write_mod`

## Requirements
- R1: While idle, and at once when reset is asserted, field_o is 0 and done_o is 0.
- R2: After start, field_o goes high and stays high for exactly CHARGE_US microseconds (CHARGE_US*CLKS_PER_US clocks) before the first bit gap.
- R3: A 1 bit is field_o low for ONE_OFF_US microseconds, then high for SLOT_US-ONE_OFF_US microseconds.
- R4: A 0 bit is field_o low for ZERO_OFF_US microseconds, then high for SLOT_US-ZERO_OFF_US microseconds.
- R5: The 112 transmitted bits, first bit at index 0, equal {8'h03, 8'h00, check[15:0], data[63:0], 8'hEB, 8'hBB}. Every byte goes LSB first, and the check low byte goes before the high byte.
- R6: When auto_check_i is 0 and check_i is nonzero, frame bits [95:80] equal check_i.
- R7: When check_i is 0, frame bits [95:80] equal a CRC-16 over the eight data bytes, lowest byte first. The CRC starts from 0, is reflected, and uses the polynomial 0x8408, with data bits fed LSB first.
- R8: When auto_check_i is 1, the computed CRC of R7 is sent whatever check_i holds.
- R9: After the on-part of the last bit slot, field_o stays high for a further PROG_US microseconds, then goes low.
- R10: done_o is high for exactly one cycle: the first cycle in which field_o is low again after the programming period.
- R11: A start strobe while a frame is in progress is ignored, and the frame in progress goes out unchanged.
- R12: data_i, check_i and auto_check_i are sampled only at an accepted start, so later changes do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to send a frame |
| data_i | input | 64 | Data word to program |
| check_i | input | 16 | Supplied check value; 0 requests the computed CRC |
| auto_check_i | input | 1 | 1 forces the computed CRC to be sent |
| field_o | output | 1 | Field enable to the antenna driver (1 = field on) |
| done_o | output | 1 | One-cycle pulse at the end of the programming period |

## Verification
The bench decodes field_o back into bits by measuring the length of every low run and every high run. It then compares the recovered frame and each duration with values it computes itself. The data words are chosen so that every frame mixes 1 and 0 slots, which makes a swapped gap length or a swapped byte order show up. The check-value patterns tell apart verbatim forwarding (nonzero with the flag clear), CRC on a zero value, CRC forced by the flag, and the all-zero data case whose CRC is also zero. Inputs changed during a frame and a start held high during a frame tell latched capture apart from live use. A reset in the middle of a frame shows that the field drops at once.

// File: rtl/lfw_pkg.sv
package lfw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CRC,
    ST_CHARGE,
    ST_BITS,
    ST_PROG
  } lfw_state_e;

  localparam int DATA_BYTES = 8;
  localparam int DATA_BITS  = DATA_BYTES * 8;
  localparam int FRAME_BITS = 112;

  localparam logic [7:0]  KEY_BYTE  = 8'hBB;
  localparam logic [7:0]  PASS_BYTE = 8'hEB;
  localparam logic [15:0] TRAILER   = 16'h0300;
  localparam logic [15:0] CRC_POLY  = 16'h8408;

  // reflected byte update, data LSB first
  function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                              input logic [7:0]  b);
    logic [15:0] c;
    c = crc_in ^ {8'h00, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/lfw_us_tick.sv
module lfw_us_tick #(
  parameter int CLKS_PER_US = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int DIV_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_US - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (!en_i)           div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end

  assign tick_o = en_i && (div_q == DIV_LAST);
endmodule

// File: rtl/lfw_crc_engine.sv
module lfw_crc_engine
  import lfw_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic                 done_o,
  output logic [15:0]          crc_o
);
  localparam int CNT_W = $clog2(DATA_BYTES + 1);

  logic [DATA_BITS-1:0] sh_q;
  logic [CNT_W-1:0]     left_q;
  logic [15:0]          crc_q;
  logic                 done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      crc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        sh_q   <= data_i;
        left_q <= CNT_W'(DATA_BYTES);
        crc_q  <= '0;
      end else if (left_q != '0) begin
        crc_q  <= crc16_byte(crc_q, sh_q[7:0]);
        sh_q   <= sh_q >> 8;
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign crc_o  = crc_q;
endmodule

// File: rtl/lfw_slot_shaper.sv
module lfw_slot_shaper #(
  parameter int SLOT_US     = 2000,
  parameter int ONE_OFF_US  = 1000,
  parameter int ZERO_OFF_US = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic bit_i,
  output logic gap_o,
  output logic end_o
);
  localparam int SLOT_W = $clog2(SLOT_US + 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_US - 1);

  logic [SLOT_W-1:0] us_q;
  logic [SLOT_W-1:0] off_len;

  assign off_len = bit_i ? SLOT_W'(ONE_OFF_US) : SLOT_W'(ZERO_OFF_US);
  assign end_o   = en_i && tick_i && (us_q == SLOT_LAST);
  assign gap_o   = en_i && (us_q < off_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     us_q <= '0;
    else if (!en_i)  us_q <= '0;
    else if (end_o)  us_q <= '0;
    else if (tick_i) us_q <= us_q + 1'b1;
  end
endmodule

// File: rtl/lfw_write_mod.sv
module lfw_write_mod
  import lfw_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int CHARGE_US   = 50000,
  parameter int PROG_US     = 50000,
  parameter int SLOT_US     = 2000,
  parameter int ONE_OFF_US  = 1000,
  parameter int ZERO_OFF_US = 300
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [63:0] data_i,
  input  logic [15:0] check_i,
  input  logic        auto_check_i,
  output logic        field_o,
  output logic        done_o
);
  localparam int PH_MAX = (CHARGE_US > PROG_US) ? CHARGE_US : PROG_US;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int BIT_W  = $clog2(FRAME_BITS + 1);

  lfw_state_e           st_q;
  logic [DATA_BITS-1:0] data_q;
  logic [15:0]          chk_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [BIT_W-1:0]     bits_left_q;
  logic [PH_W-1:0]      ph_cnt_q;
  logic                 done_q;

  logic        busy, us_tick, in_phase, phase_end;
  logic [PH_W-1:0] phase_last;
  logic        crc_start, crc_done;
  logic [15:0] crc_val;
  logic        slot_gap, slot_end;

  assign busy       = (st_q != ST_IDLE);
  assign in_phase   = (st_q == ST_CHARGE) || (st_q == ST_PROG);
  assign phase_last = (st_q == ST_CHARGE) ? PH_W'(CHARGE_US - 1) : PH_W'(PROG_US - 1);
  assign phase_end  = in_phase && us_tick && (ph_cnt_q == phase_last);
  assign crc_start  = (st_q == ST_IDLE) && start_i && (auto_check_i || (check_i == 16'h0000));

  lfw_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_phase || (st_q == ST_BITS)),
    .tick_o (us_tick)
  );

  lfw_crc_engine u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (crc_start),
    .data_i  (data_i),
    .done_o  (crc_done),
    .crc_o   (crc_val)
  );

  lfw_slot_shaper #(
    .SLOT_US     (SLOT_US),
    .ONE_OFF_US  (ONE_OFF_US),
    .ZERO_OFF_US (ZERO_OFF_US)
  ) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (st_q == ST_BITS),
    .tick_i (us_tick),
    .bit_i  (frame_q[0]),
    .gap_o  (slot_gap),
    .end_o  (slot_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ph_cnt_q <= '0;
    else if (phase_end) ph_cnt_q <= '0;
    else if (in_phase && us_tick) ph_cnt_q <= ph_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      data_q      <= '0;
      chk_q       <= '0;
      frame_q     <= '0;
      bits_left_q <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          data_q <= data_i;
          chk_q  <= check_i;
          st_q   <= crc_start ? ST_CRC : ST_CHARGE;
        end
        ST_CRC: if (crc_done) begin
          chk_q <= crc_val;
          st_q  <= ST_CHARGE;
        end
        ST_CHARGE: if (phase_end) begin
          frame_q     <= {TRAILER, chk_q, data_q, PASS_BYTE, KEY_BYTE};
          bits_left_q <= BIT_W'(FRAME_BITS);
          st_q        <= ST_BITS;
        end
        ST_BITS: if (slot_end) begin
          frame_q     <= frame_q >> 1;
          bits_left_q <= bits_left_q - 1'b1;
          if (bits_left_q == BIT_W'(1)) st_q <= ST_PROG;
        end
        ST_PROG: if (phase_end) begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign field_o = in_phase || ((st_q == ST_BITS) && !slot_gap);
  assign done_o  = done_q;
endmodule

// File: rtl/lfw_write_mod_chk.sv
module lfw_write_mod_chk #(
  parameter int CLKS_PER_US = 50,
  parameter int ONE_OFF_US  = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic field_o,
  input logic done_o,
  input logic busy_i,
  input logic tick_i
);
  localparam int GAP_MAX = ONE_OFF_US * CLKS_PER_US;

  logic seen_high_q;
  int   low_run_q;
  int   since_tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_high_q  <= 1'b0;
      low_run_q    <= 0;
      since_tick_q <= 0;
    end else begin
      seen_high_q  <= busy_i && (seen_high_q || field_o);
      low_run_q    <= (busy_i && seen_high_q && !field_o) ? low_run_q + 1 : 0;
      since_tick_q <= (!seen_high_q || tick_i) ? 0 : since_tick_q + 1;
    end
  end

  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !field_o);

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_after_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_i && !field_o && $past(field_o)));

  a_r11_start_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i && !done_o) |=> (busy_i || done_o));

  a_r3_gap_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_run_q <= GAP_MAX);

  a_r2_tick_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && seen_high_q) |-> (since_tick_q < CLKS_PER_US));
endmodule

bind lfw_write_mod lfw_write_mod_chk #(
  .CLKS_PER_US (CLKS_PER_US),
  .ONE_OFF_US  (ONE_OFF_US)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .field_o (field_o),
  .done_o  (done_o),
  .busy_i  (busy),
  .tick_i  (us_tick)
);

// File: tb/lfw_write_mod_test.sv
module lfw_write_mod_test;
  localparam int K      = 2;
  localparam int CHG    = 40;
  localparam int PRG    = 30;
  localparam int SLOT   = 20;
  localparam int OFF1   = 10;
  localparam int OFF0   = 3;
  localparam int NBITS  = 112;
  localparam int LIM    = 1000;

  // {auto, check, data}
  localparam logic [80:0] VEC [5] = '{
    {1'b0, 16'hA55A, 64'h0123_4567_89AB_CDEF},
    {1'b0, 16'h0000, 64'hFEDC_BA98_7654_3210},
    {1'b1, 16'h1357, 64'h0000_0000_0000_0001},
    {1'b0, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 16'h0000, 64'h0000_0000_0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] data_i = '0;
  logic [15:0] check_i = '0;
  logic        auto_check_i = 1'b0;
  logic        field_o, done_o;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  lfw_write_mod #(
    .CLKS_PER_US (K),
    .CHARGE_US   (CHG),
    .PROG_US     (PRG),
    .SLOT_US     (SLOT),
    .ONE_OFF_US  (OFF1),
    .ZERO_OFF_US (OFF0)
  ) uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .data_i       (data_i),
    .check_i      (check_i),
    .auto_check_i (auto_check_i),
    .field_o      (field_o),
    .done_o       (done_o)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input logic [63:0] d);
    logic [15:0] r;
    logic fb;
    r = 16'h0000;
    for (int i = 0; i < 64; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  // poke: 0 none, 1 change inputs mid-frame (R12), 2 hold start mid-frame (R11)
  task automatic do_frame(input logic [63:0] d, input logic [15:0] c,
                          input logic a, input int poke, input string tag);
    logic [15:0]  ec;
    logic [111:0] expf, got;
    int n, lo, hi, exp_hi, gap_bad, on1_bad, on0_bad, last_bad;
    bit b;
    ec   = (a || c == 16'h0000) ? crc_ref(d) : c;
    expf = {8'h03, 8'h00, ec, d, 8'hEB, 8'hBB};
    got = '0; gap_bad = 0; on1_bad = 0; on0_bad = 0; last_bad = 0;
    @(negedge clk);
    data_i = d; check_i = c; auto_check_i = a; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!field_o && n < 200) begin n++; @(negedge clk); end
    hi = 0;
    while (field_o && hi < LIM) begin hi++; @(negedge clk); end
    chk(hi == CHG * K, "R2 charge length", hi, CHG * K);
    for (int i = 0; i < NBITS; i++) begin
      if (poke == 1 && i == 20) begin
        data_i = ~d; check_i = ~c ^ 16'h0101; auto_check_i = ~a;
      end
      lo = 0;
      while (!field_o && lo < LIM) begin lo++; @(negedge clk); end
      if (poke == 2 && i == 50) begin
        data_i = ~d; check_i = 16'h7E7E; start_i = 1'b1;
      end
      hi = 0;
      while (field_o && hi < LIM) begin hi++; @(negedge clk); end
      start_i = 1'b0;
      b = (lo == OFF1 * K);
      got[i] = b;
      if (lo != OFF1 * K && lo != OFF0 * K) gap_bad++;
      exp_hi = (SLOT - (b ? OFF1 : OFF0)) * K + ((i == NBITS - 1) ? PRG * K : 0);
      if (hi != exp_hi) begin
        if (i == NBITS - 1) last_bad++;
        else if (b) on1_bad++;
        else on0_bad++;
      end
    end
    chk(done_o == 1'b1, "R10 done at field drop", done_o, 1);
    chk(gap_bad == 0 && on1_bad == 0, "R3 one-bit timing", gap_bad + on1_bad, 0);
    chk(on0_bad == 0, "R4 zero-bit timing", on0_bad, 0);
    chk(last_bad == 0, "R9 programming hold", last_bad, 0);
    chk(got == expf, "R5 frame content", got, expf);
    chk(got[95:80] == ec, tag, got[95:80], ec);
    @(negedge clk);
    chk(done_o == 1'b0, "R10 done single cycle", done_o, 0);
    chk(field_o == 1'b0, "R1 idle after frame", field_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk(field_o == 1'b0 && done_o == 1'b0, "R1 in reset", {field_o, done_o}, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(field_o == 1'b0 && done_o == 1'b0, "R1 idle after reset", {field_o, done_o}, 0);

    for (int v = 0; v < 5; v++) begin
      logic [80:0] e;
      string t;
      e = VEC[v];
      t = e[80] ? "R8 forced crc" : (e[79:64] == 16'h0 ? "R7 crc on zero check" : "R6 verbatim check");
      do_frame(e[63:0], e[79:64], e[80], 0, t);
    end

    do_frame(64'h5A5A_0F0F_C3C3_9696, 16'h2468, 1'b0, 1, "R12 inputs latched");
    do_frame(64'h1111_2222_4444_8888, 16'h0000, 1'b0, 2, "R11 start ignored");

    // reset during a frame
    @(negedge clk);
    data_i = 64'hDEAD_BEEF_0BAD_F00D; check_i = 16'h0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (300) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(field_o == 1'b0, "R1 async reset drops field", field_o, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk);
    chk(field_o == 1'b0 && done_o == 1'b0, "R1 idle after mid-frame reset", {field_o, done_o}, 0);
    do_frame(64'h0000_0000_8000_0001, 16'h0BB0, 1'b0, 0, "R6 after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule